// File: doc/BRIEF.md
# Gated Reload Timer with PWM

A 16-bit up-counter whose count events come from the logical AND of two tick sources. Each source is picked by its own 3-bit code, so one can serve as a gate for the other. Each source may be a fixed-rate strobe, a constant high level or an external input. The counter steps by one on every rising edge of that combined signal. When it steps past its all-ones value, four things happen together: it reloads a programmed value, sets an interrupt flag (if interrupts are enabled), flips a toggle output, and advances a 4-bit PWM phase counter.

A second output is a pulse-width signal framed in 16 overflows. It is high while the phase counter is below a 4-bit width field. Software controls the block through four word registers: data/reload, control, enable and interrupt clear. A read of the data register returns the live count. The fixed-rate strobes are one-cycle pulses made outside the block. The two external inputs are levels that are assumed to be synchronous to `clk`.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset the count, reload value, control, enable, interrupt flag, toggle output, phase counter and PWM output are all zero.
- R2: Source A code (control bits 2:0): 000/001/110 give constant low, 010 the 32768 Hz strobe, 011 the 8192 Hz strobe, 100 the 4096 Hz strobe, 101 constant high, 111 the external input `ext_a`.
- R3: Source B code (control bits 5:3): 000 the 2048 Hz strobe, 001 1024 Hz, 010 256 Hz, 011 the timebase strobe, 100 4 Hz, 101 2 Hz, 110 constant high, 111 the external input `ext_b`.
- R4: While enabled, the count rises by exactly one in the clock edge at which the AND of the two sources is high after being low in the previous cycle. A combined level held high counts once. While disabled, the count does not move on source edges.
- R5: A count event at 0xFFFF loads the value last written to the data register instead of wrapping.
- R6: Register addresses are 0 data, 1 control, 2 enable (bit 0), 3 interrupt clear (bit 0). A data write always updates the reload value. It also loads the count only while the timer is disabled. A read of address 0 returns the count.
- R7: Each overflow inverts `tog_out`. No other event changes it.
- R8: Control bit 10 enables interrupts. An overflow with it set raises `irq`. `irq` stays high until a write to address 3 with bit 0 set. A write with bit 0 clear has no effect. An overflow with bit 10 clear leaves `irq` unchanged.
- R9: Each overflow advances the 4-bit phase modulo 16. `pwm_out` is high exactly while the phase is below the width field (control bits 9:6), so width 0 keeps it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | 32768 Hz one-cycle strobe |
| tick_8k | input | 1 | 8192 Hz strobe |
| tick_4k | input | 1 | 4096 Hz strobe |
| tick_2k | input | 1 | 2048 Hz strobe |
| tick_1k | input | 1 | 1024 Hz strobe |
| tick_256 | input | 1 | 256 Hz strobe |
| tick_4 | input | 1 | 4 Hz strobe |
| tick_2 | input | 1 | 2 Hz strobe |
| tick_tmb | input | 1 | Timebase strobe |
| ext_a | input | 1 | External level for source A |
| ext_b | input | 1 | External level for source B |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| irq | output | 1 | Interrupt flag |
| tog_out | output | 1 | Toggles on overflow |
| pwm_out | output | 1 | Pulse-width output |

## Verification
All 64 pairs of source codes are driven with a pseudo-random pattern on every strobe and external input. This covers constant, strobe and external selections, masking by a low source, and held-high levels that must count only once. The count after each pair shows which source was wired to which code. Directed runs from 0xFFFD cross the overflow boundary with interrupts enabled and then disabled. They also write the clear bit with 0 and with 1, and rewrite the reload value while running. Together these separate reload from wrap, flag set from flag hold, and a direct load from a reload-only update. With a reload of 0xFFFF every event overflows, and sweeping all 16 widths over full 16-step frames checks the phase comparison at every point.

// File: rtl/grt_pkg.sv
package grt_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CTRL = 2'd1,
    REG_EN   = 2'd2,
    REG_CLR  = 2'd3
  } grt_reg_e;

  localparam int SEL_W   = 3;
  localparam int SEL_A_LO = 0;
  localparam int SEL_B_LO = 3;
  localparam int WID_LO   = 6;
endpackage

// File: rtl/grt_src_sel.sv
module grt_src_sel
  import grt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  input  logic             tick_32k,
  input  logic             tick_8k,
  input  logic             tick_4k,
  input  logic             tick_2k,
  input  logic             tick_1k,
  input  logic             tick_256,
  input  logic             tick_4,
  input  logic             tick_2,
  input  logic             tick_tmb,
  input  logic             ext_a,
  input  logic             ext_b,
  output logic             gated,
  output logic             edge_evt
);
  logic gated_q;
  logic src_a;
  logic src_b;

  function automatic logic pick_a(input logic [SEL_W-1:0] s, input logic t32, input logic t8,
                                  input logic t4k, input logic ex);
    case (s)
      3'b010:  pick_a = t32;
      3'b011:  pick_a = t8;
      3'b100:  pick_a = t4k;
      3'b101:  pick_a = 1'b1;
      3'b111:  pick_a = ex;
      default: pick_a = 1'b0;
    endcase
  endfunction

  function automatic logic pick_b(input logic [SEL_W-1:0] s, input logic t2k, input logic t1k,
                                  input logic t256, input logic ttb, input logic t4,
                                  input logic t2, input logic ex);
    case (s)
      3'b000:  pick_b = t2k;
      3'b001:  pick_b = t1k;
      3'b010:  pick_b = t256;
      3'b011:  pick_b = ttb;
      3'b100:  pick_b = t4;
      3'b101:  pick_b = t2;
      3'b110:  pick_b = 1'b1;
      default: pick_b = ex;
    endcase
  endfunction

  assign src_a    = pick_a(sel_a, tick_32k, tick_8k, tick_4k, ext_a);
  assign src_b    = pick_b(sel_b, tick_2k, tick_1k, tick_256, tick_tmb, tick_4, tick_2, ext_b);
  assign gated    = src_a & src_b;
  assign edge_evt = gated & ~gated_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gated_q <= 1'b0;
    else        gated_q <= gated;
  end
endmodule

// File: rtl/grt_counter.sv
module grt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] CNT_MAX = '1;

  function automatic logic [W-1:0] incr(input logic [W-1:0] v);
    incr = v + W'(1);
  endfunction

  assign ovf = step && (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (ovf)     cnt <= reload_val;
    else if (step)    cnt <= incr(cnt);
    else if (load_en) cnt <= load_val;
  end
endmodule

// File: rtl/grt_pwm.sv
module grt_pwm #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovf,
  input  logic [PH_W-1:0] width,
  output logic [PH_W-1:0] phase,
  output logic            tog,
  output logic            pwm
);
  function automatic logic above(input logic [PH_W-1:0] w, input logic [PH_W-1:0] p);
    above = (p < w);
  endfunction

  assign pwm = above(width, phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      tog   <= 1'b0;
    end else if (ovf) begin
      phase <= phase + PH_W'(1);
      tog   <= ~tog;
    end
  end
endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer
  import grt_pkg::*;
#(
  parameter int W    = 16,
  parameter int PH_W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_32k,
  input  logic         tick_8k,
  input  logic         tick_4k,
  input  logic         tick_2k,
  input  logic         tick_1k,
  input  logic         tick_256,
  input  logic         tick_4,
  input  logic         tick_2,
  input  logic         tick_tmb,
  input  logic         ext_a,
  input  logic         ext_b,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq,
  output logic         tog_out,
  output logic         pwm_out
);
  localparam int IE_BIT = WID_LO + PH_W;
  localparam int CTRL_W = IE_BIT + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [W-1:0]      reload_q;
  logic [W-1:0]      cnt_q;
  logic              en_q;
  logic              irq_q;
  logic              gated;
  logic              edge_evt;
  logic              step_evt;
  logic              ovf_evt;
  logic              ie;
  logic [PH_W-1:0]   pw_sel;
  logic [PH_W-1:0]   phase;
  logic              wr_data_sel;
  logic              clr_evt;

  assign ie          = ctrl_q[IE_BIT];
  assign pw_sel      = ctrl_q[WID_LO +: PH_W];
  assign step_evt    = en_q & edge_evt;
  assign wr_data_sel = wr_en && (wr_addr == REG_DATA);
  assign clr_evt     = wr_en && (wr_addr == REG_CLR) && wr_data[0];

  grt_src_sel u_src (
    .clk(clk), .rst_n(rst_n),
    .sel_a(ctrl_q[SEL_A_LO +: SEL_W]), .sel_b(ctrl_q[SEL_B_LO +: SEL_W]),
    .tick_32k(tick_32k), .tick_8k(tick_8k), .tick_4k(tick_4k), .tick_2k(tick_2k),
    .tick_1k(tick_1k), .tick_256(tick_256), .tick_4(tick_4), .tick_2(tick_2),
    .tick_tmb(tick_tmb), .ext_a(ext_a), .ext_b(ext_b),
    .gated(gated), .edge_evt(edge_evt)
  );

  grt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step_evt),
    .load_en(wr_data_sel && !en_q), .load_val(wr_data),
    .reload_val(reload_q), .cnt(cnt_q), .ovf(ovf_evt)
  );

  grt_pwm #(.PH_W(PH_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_evt), .width(pw_sel),
    .phase(phase), .tog(tog_out), .pwm(pwm_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      en_q     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_DATA: reload_q <= wr_data;
        REG_CTRL: ctrl_q   <= wr_data[CTRL_W-1:0];
        REG_EN:   en_q     <= wr_data[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              irq_q <= 1'b0;
    else if (ovf_evt && ie)  irq_q <= 1'b1;
    else if (clr_evt)        irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    case (rd_addr)
      REG_DATA: rd_data = cnt_q;
      REG_CTRL: rd_data = W'(ctrl_q);
      REG_EN:   rd_data = W'(en_q);
      default:  rd_data = W'(irq_q);
    endcase
  end
endmodule

// File: rtl/grt_checker.sv
module grt_checker #(
  parameter int W    = 16,
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    cnt,
  input logic [W-1:0]    reload,
  input logic            step,
  input logic            ovf,
  input logic            en,
  input logic            ie,
  input logic [PH_W-1:0] width,
  input logic            tog,
  input logic            irq,
  input logic            pwm,
  input logic            wr_en,
  input logic [1:0]      wr_addr,
  input logic [W-1:0]    wr_data
);
  localparam logic [W-1:0] MAXV = '1;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt != MAXV) |=> cnt == W'($past(cnt) + 1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !(wr_en && wr_addr == 2'd0 && !en)) |=> $stable(cnt)); // R4
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt == $past(reload)); // R5
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && !en) |=> cnt == $past(wr_data)); // R6
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> tog != $past(tog)); // R7
  AST_TOG_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(tog)); // R7
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ie) |=> irq); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(wr_en && wr_addr == 2'd3 && wr_data[0])) |=> irq); // R8
  AST_PWM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (width == '0) |-> !pwm); // R9
endmodule

bind gated_reload_timer grt_checker #(.W(W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .reload(reload_q), .step(step_evt),
  .ovf(ovf_evt), .en(en_q), .ie(ie), .width(pw_sel), .tog(tog_out), .irq(irq),
  .pwm(pwm_out), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/gated_reload_timer_tb.sv
`timescale 1ns/1ps
module gated_reload_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] stim = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq, tog_out, pwm_out;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state, kept from the requirements
  logic [15:0] m_cnt = '0, m_reload = '0;
  logic [10:0] m_ctrl = '0;
  logic        m_en = 1'b0, m_irq = 1'b0, m_tog = 1'b0, m_prev = 1'b0;
  logic [3:0]  m_phase = '0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  gated_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n),
    .tick_32k(stim[0]), .tick_8k(stim[1]), .tick_4k(stim[2]), .tick_2k(stim[3]),
    .tick_1k(stim[4]), .tick_256(stim[5]), .tick_4(stim[6]), .tick_2(stim[7]),
    .tick_tmb(stim[8]), .ext_a(stim[9]), .ext_b(stim[10]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq), .tog_out(tog_out), .pwm_out(pwm_out)
  );

  function automatic logic src_a(input logic [2:0] c, input logic [10:0] s);
    case (c)
      3'b010: return s[0];
      3'b011: return s[1];
      3'b100: return s[2];
      3'b101: return 1'b1;
      3'b111: return s[9];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic src_b(input logic [2:0] c, input logic [10:0] s);
    case (c)
      3'b000: return s[3];
      3'b001: return s[4];
      3'b010: return s[5];
      3'b011: return s[8];
      3'b100: return s[6];
      3'b101: return s[7];
      3'b110: return 1'b1;
      default: return s[10];
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One clock; starts and ends at a falling edge
  task automatic cyc();
    logic g, stp, ov, old_en, old_ie;
    g      = src_a(m_ctrl[2:0], stim) && src_b(m_ctrl[5:3], stim);
    stp    = m_en && g && !m_prev;
    ov     = stp && (m_cnt == 16'hFFFF);
    old_en = m_en;
    old_ie = m_ctrl[10];
    @(posedge clk);
    m_prev = g;
    if (ov) begin
      m_cnt = m_reload; m_tog = !m_tog; m_phase = m_phase + 4'd1;
    end else if (stp) m_cnt = m_cnt + 16'd1;
    else if (wr_en && wr_addr == 2'd0 && !old_en) m_cnt = wr_data;
    if (ov && old_ie) m_irq = 1'b1;
    else if (wr_en && wr_addr == 2'd3 && wr_data[0]) m_irq = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        2'd0: m_reload = wr_data;
        2'd1: m_ctrl   = wr_data[10:0];
        2'd2: m_en     = wr_data[0];
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic pulse2k();
    stim[3] = 1'b1; cyc(); stim[3] = 1'b0; cyc();
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a);
    logic [15:0] e;
    rd_addr = a;
    #0.5;
    case (a)
      2'd0: e = m_cnt;
      2'd1: e = {5'd0, m_ctrl};
      2'd2: e = {15'd0, m_en};
      default: e = {15'd0, m_irq};
    endcase
    check(req, rd_data, e);
  endtask

  task automatic out_chk(input string req);
    check({req, " irq"}, {15'd0, irq}, {15'd0, m_irq});
    check({req, " tog"}, {15'd0, tog_out}, {15'd0, m_tog});
    check({req, " pwm"}, {15'd0, pwm_out}, {15'd0, m_phase < m_ctrl[9:6]});
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) rd_chk("R1 reset", 2'(a));
    out_chk("R1 reset");

    // R2 R3 R4: every source pair under a pseudo-random stimulus
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        wr(2'd2, 16'd0);
        wr(2'd1, 16'((b << 3) | a));
        wr(2'd0, 16'h1000);
        wr(2'd2, 16'd1);
        for (int k = 0; k < 40; k++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          stim = lf[10:0];
          cyc();
        end
        stim = '0;
        wr(2'd2, 16'd0);
        rd_chk("R2 R3 R4 sweep count", 2'd0);
      end
    end

    // R4: disabled timer ignores edges
    wr(2'd1, 16'h0405);           // A const1, B 2048 Hz, ie set
    wr(2'd0, 16'h0042);
    pulse2k();
    rd_chk("R4 disabled", 2'd0);
    check("R4 disabled literal", rd_data, 16'h0042);

    // R5 R7 R8 overflow with interrupt enabled
    wr(2'd0, 16'hFFFD);
    wr(2'd2, 16'd1);
    pulse2k(); pulse2k();
    rd_chk("R4 step", 2'd0);
    check("R4 step literal", rd_data, 16'hFFFF);
    pulse2k();
    rd_chk("R5 reload", 2'd0);
    check("R5 reload literal", rd_data, 16'hFFFD);
    out_chk("R7 R8 overflow");
    check("R8 irq literal", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'd0);
    out_chk("R8 clear with 0 ignored");
    wr(2'd3, 16'd1);
    out_chk("R8 clear");
    rd_chk("R8 flag read", 2'd3);

    // R6: data write while running changes reload only
    wr(2'd0, 16'hFFFE);
    rd_chk("R6 running write keeps count", 2'd0);
    check("R6 literal", rd_data, 16'hFFFD);
    wr(2'd1, 16'h0005);           // interrupts off
    pulse2k(); pulse2k(); pulse2k();
    rd_chk("R6 new reload used", 2'd0);
    check("R6 reload literal", rd_data, 16'hFFFE);
    out_chk("R8 no set when disabled R7");
    check("R8 irq stays low", {15'd0, irq}, 16'd0);
    rd_chk("R6 ctrl read", 2'd1);
    rd_chk("R6 en read", 2'd2);

    // R9: every width over full 16-step frames (each event overflows)
    for (int w = 0; w < 16; w++) begin
      wr(2'd2, 16'd0);
      wr(2'd1, 16'((w << 6) | 5));
      wr(2'd0, 16'hFFFF);
      wr(2'd2, 16'd1);
      for (int p = 0; p < 16; p++) begin
        pulse2k();
        out_chk("R9 pwm frame");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule